// File: doc/BRIEF.md
# Binary FSK Tone Modulator

This block turns a serial transmit bit into a digital sinusoid whose frequency moves between two tones: a mark tone for a 1 and a space tone for a 0. A phase accumulator advances once per sample period by an increment chosen from the current bit, the frequency family (Bell 202 or V.23) and the speed (1200 bps forward channel or slow backward channel). The top bits of the accumulator index a sine table, and the looked-up value leaves the block as a signed sample with a one-cycle valid pulse.

The block also paces its own bit source. A fractional divider running from the master clock raises a one-cycle bit strobe at the chosen bit rate, and the transmit bit is captured on the edge that follows it. A tone change therefore lands on a bit boundary and keeps the phase continuous, because only the increment changes. When the FSK path is switched off, or when the tone source is set to the dual-tone path, the block outputs mid-scale (zero), holds its phase and stops the bit strobe.

Top module: `fsk_tone_mod`

## Requirements
- R1: While `rstN` is low, `sample` is 0, `sampleValid` is 0 and `bitStrobe` is 0. The phase accumulator and the held bit both restart at 0.
- R2: `sampleValid` pulses high for one cycle once every `SAMPLE_DIV` clock cycles, whether or not the block is active.
- R3: The block is active only when `fskEnable` is 1 and `dtmfSelect` is 0. While it is inactive, every valid sample is 0 (mid-scale), no `bitStrobe` is produced and the phase is held.
- R4: `bitStrobe` is a one-cycle pulse produced by a fractional divider that adds the bit rate to an accumulator modulo `CLK_HZ` each cycle. The rate is 1200 when `highSpeed` is 1; otherwise it is 150 with `bellMode`=1 and 75 with `bellMode`=0. Consecutive strobes at one rate are floor or ceil of `CLK_HZ`/rate cycles apart.
- R5: `txBit` is captured only at the clock edge that follows a cycle with `bitStrobe` high. Changes of `txBit` at any other time have no effect on the output.
- R6: The phase increment is round(f * 2^`PHASE_W` * `SAMPLE_DIV` / `CLK_HZ`). The tone f is chosen as follows:
  - `bellMode`=1, `highSpeed`=1: mark (bit 1) 1200 Hz, space (bit 0) 2200 Hz.
  - `bellMode`=1, `highSpeed`=0: mark 387 Hz, space 487 Hz.
  - `bellMode`=0, `highSpeed`=1: mark 1300 Hz, space 2100 Hz.
  - `bellMode`=0, `highSpeed`=0: mark 390 Hz, space 450 Hz.
- R7: On each valid sample while active, `sample` equals round((2^(`SAMPLE_W`-1)-1) * sin(2*pi*p / 2^`LUT_AW`)) in two's complement. Here p is the top `LUT_AW` bits of the phase before that sample's update, and the update uses the bit held before that edge.
- R8: The phase accumulator is cleared only by reset. A tone change, or a return from the inactive state, continues from the current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fskEnable | input | 1 | FSK path on (1) or held at mid-scale (0) |
| highSpeed | input | 1 | 1200 bps tones and rate (1) or backward-channel tones and rate (0) |
| bellMode | input | 1 | Bell 202 tone set (1) or V.23 tone set (0) |
| dtmfSelect | input | 1 | Tone source is the dual-tone path (1), which suppresses FSK |
| txBit | input | 1 | Serial bit to transmit, sampled after a bit strobe |
| bitStrobe | output | 1 | One-cycle pulse at the bit rate that paces the bit source |
| sample | output | SAMPLE_W | Signed sine sample, 0 at mid-scale |
| sampleValid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The main instance is built with `CLK_HZ`=96000 and `SAMPLE_DIV`=4. These values give exact bit periods of 80, 640 and 1280 cycles and a 24 kHz sample rate, so many bits, tone switches and enable toggles fit in a short run. Every sample is compared against a bench phase model. A second instance keeps the default 3.579545 MHz clock and checks the fractional divider, where the 1200 and 150 bps periods are not whole numbers of cycles and must alternate between floor and ceil.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

  typedef struct packed {
    logic sampleTick;
    logic bitTick;
    logic active;
  } fskStrobes_t;

  // sel = {bellMode, highSpeed, bit}
  function automatic int toneHz(input int sel);
    case (sel)
      7: return 1200;
      6: return 2200;
      5: return 387;
      4: return 487;
      3: return 1300;
      2: return 2100;
      1: return 390;
      default: return 450;
    endcase
  endfunction

  function automatic longint toneInc(input int freqHz, input int phaseW,
                                     input int clkHz, input int sampleDiv);
    longint num;
    num = (longint'(freqHz) * longint'(sampleDiv)) << phaseW;
    return (num + longint'(clkHz) / 2) / longint'(clkHz);
  endfunction

  function automatic int sineEntry(input int idx, input int depth, input int amp);
    real x;
    x = amp * $sin(6.283185307179586 * idx / depth);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

endpackage

// File: rtl/fsk_mod_ctrl.sv
module fsk_mod_ctrl
  import fsk_mod_pkg::*;
#(
  parameter int CLK_HZ       = 3579545,
  parameter int SAMPLE_DIV   = 4,
  parameter int HI_BAUD      = 1200,
  parameter int LO_BAUD_BELL = 150,
  parameter int LO_BAUD_V23  = 75
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fskEnable,
  input  logic        dtmfSelect,
  input  logic        bellMode,
  input  logic        highSpeed,
  output fskStrobes_t strobes
);
  localparam int ACC_W = $clog2(CLK_HZ) + 1;
  localparam logic [ACC_W:0] LIMIT = (ACC_W + 1)'(CLK_HZ);

  logic active;
  logic sampleTick;
  logic bitTickQ;
  logic [ACC_W-1:0] fracAcc;
  logic [ACC_W:0] baudStep;
  logic [ACC_W:0] accSum;

  assign active = fskEnable & ~dtmfSelect;

  generate
    if (SAMPLE_DIV > 1) begin : g_div
      localparam int CW = $clog2(SAMPLE_DIV);
      localparam logic [CW-1:0] LAST = CW'(SAMPLE_DIV - 1);
      logic [CW-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) divCnt <= '0;
        else if (divCnt == LAST) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign sampleTick = (divCnt == LAST);
      // R2: sample ticks never come back to back
      a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
        sampleTick |=> !sampleTick);
    end else begin : g_nodiv
      assign sampleTick = 1'b1;
    end
  endgenerate

  always_comb begin
    if (highSpeed) baudStep = (ACC_W + 1)'(HI_BAUD);
    else if (bellMode) baudStep = (ACC_W + 1)'(LO_BAUD_BELL);
    else baudStep = (ACC_W + 1)'(LO_BAUD_V23);
  end

  assign accSum = {1'b0, fracAcc} + baudStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fracAcc  <= '0;
      bitTickQ <= 1'b0;
    end else if (!active) begin
      fracAcc  <= '0;
      bitTickQ <= 1'b0;
    end else if (accSum >= LIMIT) begin
      fracAcc  <= ACC_W'(accSum - LIMIT);
      bitTickQ <= 1'b1;
    end else begin
      fracAcc  <= accSum[ACC_W-1:0];
      bitTickQ <= 1'b0;
    end
  end

  assign strobes = '{sampleTick: sampleTick, bitTick: bitTickQ, active: active};

  // R3: no bit strobe after an inactive cycle
  a_r3_idle_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !bitTickQ);

  // R4: bit strobe is a single-cycle pulse
  a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (!rstN)
    bitTickQ |=> !bitTickQ);

endmodule

// File: rtl/fsk_mod_datapath.sv
module fsk_mod_datapath
  import fsk_mod_pkg::*;
#(
  parameter int CLK_HZ     = 3579545,
  parameter int SAMPLE_DIV = 4,
  parameter int PHASE_W    = 24,
  parameter int LUT_AW     = 8,
  parameter int SAMPLE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fskStrobes_t                strobes,
  input  logic                       bellMode,
  input  logic                       highSpeed,
  input  logic                       txBit,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       sampleValid
);
  localparam int LUT_DEPTH = 1 << LUT_AW;
  localparam int AMP       = (1 << (SAMPLE_W - 1)) - 1;

  logic signed [SAMPLE_W-1:0] sineLut [LUT_DEPTH];
  logic [PHASE_W-1:0] incTable [8];
  logic [PHASE_W-1:0] phaseAcc;
  logic [PHASE_W-1:0] phaseStep;
  logic               curBit;

  generate
    for (genvar gi = 0; gi < LUT_DEPTH; gi++) begin : g_lut
      localparam int ENTRY = sineEntry(gi, LUT_DEPTH, AMP);
      assign sineLut[gi] = SAMPLE_W'(ENTRY);
    end
    for (genvar gt = 0; gt < 8; gt++) begin : g_inc
      localparam longint INC = toneInc(toneHz(gt), PHASE_W, CLK_HZ, SAMPLE_DIV);
      assign incTable[gt] = PHASE_W'(INC);
    end
  endgenerate

  assign phaseStep = incTable[{bellMode, highSpeed, curBit}];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curBit <= 1'b0;
    else if (strobes.bitTick) curBit <= txBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc    <= '0;
      sample      <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.sampleTick;
      if (strobes.sampleTick) begin
        if (strobes.active) begin
          sample   <= sineLut[phaseAcc[PHASE_W-1 -: LUT_AW]];
          phaseAcc <= phaseAcc + phaseStep;
        end else begin
          sample <= '0;
        end
      end
    end
  end

  // R5: held bit moves only after a bit strobe
  a_r5_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bitTick |=> $stable(curBit));

  // R3: inactive sample period yields a mid-scale valid sample
  a_r3_mid_scale: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sampleTick && !strobes.active) |=> (sampleValid && sample == '0));

  // R8: phase moves only on an active sample tick
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.sampleTick && strobes.active) |=> $stable(phaseAcc));

  // R2: valid follows every sample tick
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sampleTick |=> sampleValid);

endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod
  import fsk_mod_pkg::*;
#(
  parameter int CLK_HZ       = 3579545,
  parameter int SAMPLE_DIV   = 4,
  parameter int PHASE_W      = 24,
  parameter int LUT_AW       = 8,
  parameter int SAMPLE_W     = 8,
  parameter int HI_BAUD      = 1200,
  parameter int LO_BAUD_BELL = 150,
  parameter int LO_BAUD_V23  = 75
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fskEnable,
  input  logic                       highSpeed,
  input  logic                       bellMode,
  input  logic                       dtmfSelect,
  input  logic                       txBit,
  output logic                       bitStrobe,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       sampleValid
);
  fskStrobes_t strobes;

  fsk_mod_ctrl #(
    .CLK_HZ(CLK_HZ), .SAMPLE_DIV(SAMPLE_DIV), .HI_BAUD(HI_BAUD),
    .LO_BAUD_BELL(LO_BAUD_BELL), .LO_BAUD_V23(LO_BAUD_V23)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fskEnable(fskEnable), .dtmfSelect(dtmfSelect),
    .bellMode(bellMode), .highSpeed(highSpeed), .strobes(strobes)
  );

  fsk_mod_datapath #(
    .CLK_HZ(CLK_HZ), .SAMPLE_DIV(SAMPLE_DIV), .PHASE_W(PHASE_W),
    .LUT_AW(LUT_AW), .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bellMode(bellMode),
    .highSpeed(highSpeed), .txBit(txBit), .sample(sample), .sampleValid(sampleValid)
  );

  assign bitStrobe = strobes.bitTick;

endmodule

// File: tb/fsk_tone_mod_tb.sv
`timescale 1ns/1ps
module fsk_tone_mod_tb;
  localparam int TB_CLK = 96000;
  localparam int TB_DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fskEnable = 1'b1, highSpeed = 1'b1, bellMode = 1'b1, dtmfSelect = 1'b0, txBit = 1'b0;
  logic bitStrobe, sampleValid;
  logic signed [7:0] sample;

  logic fEn = 1'b0, fHi = 1'b1, fBell = 1'b1;
  logic fStrobe, fValid;
  logic signed [7:0] fSample;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fsk_tone_mod #(.CLK_HZ(TB_CLK), .SAMPLE_DIV(TB_DIV)) u_dut (
    .clk(clk), .rstN(rstN), .fskEnable(fskEnable), .highSpeed(highSpeed),
    .bellMode(bellMode), .dtmfSelect(dtmfSelect), .txBit(txBit),
    .bitStrobe(bitStrobe), .sample(sample), .sampleValid(sampleValid));

  fsk_tone_mod u_dutFull (
    .clk(clk), .rstN(rstN), .fskEnable(fEn), .highSpeed(fHi),
    .bellMode(fBell), .dtmfSelect(1'b0), .txBit(1'b0),
    .bitStrobe(fStrobe), .sample(fSample), .sampleValid(fValid));

  // bench model state
  logic [23:0] ph = '0;
  logic bitCur = 1'b0, bitPrev = 1'b0, pend = 1'b0, pendVal = 1'b0;
  int intervalCnt = 0;
  bit lastValid = 1'b0;
  int validGap = 0;
  bit seenValid = 1'b0;
  int segStrobes = 0;

  function automatic int benchSine(input int p);
    real v;
    v = 127.0 * $sin(2.0 * 3.141592653589793 * p / 256.0);
    return int'(v);
  endfunction

  function automatic int benchTone(input logic bell, input logic hi, input logic b);
    if (bell && hi) return b ? 1200 : 2200;
    if (bell) return b ? 387 : 487;
    if (hi) return b ? 1300 : 2100;
    return b ? 390 : 450;
  endfunction

  function automatic logic [23:0] benchInc(input logic bell, input logic hi, input logic b);
    real f;
    f = real'(benchTone(bell, hi, b)) * 16777216.0 * real'(TB_DIV) / real'(TB_CLK);
    return 24'($rtoi(f + 0.5));
  endfunction

  function automatic int benchRate(input logic bell, input logic hi);
    if (hi) return 1200;
    return bell ? 150 : 75;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step();
    bit act;
    @(negedge clk);
    bitPrev = bitCur;
    if (pend) begin bitCur = pendVal; pend = 1'b0; end
    act = fskEnable && !dtmfSelect;
    validGap++;
    if (sampleValid) begin
      if (seenValid) check(validGap == TB_DIV, "R2 valid spacing", validGap, TB_DIV);
      seenValid = 1'b1;
      validGap = 0;
      if (act) begin
        check(sample == 8'(benchSine(int'(ph[23:16]))), "R6/R7/R8 sample",
              int'(sample), benchSine(int'(ph[23:16])));
        ph = ph + benchInc(bellMode, highSpeed, bitPrev);
      end else begin
        check(sample == 8'sd0, "R3 mid-scale", int'(sample), 0);
      end
    end
    intervalCnt++;
    if (bitStrobe) begin
      segStrobes++;
      if (!act) check(1'b0, "R3 strobe while inactive", 1, 0);
      if (lastValid)
        check(intervalCnt == TB_CLK / benchRate(bellMode, highSpeed), "R4 bit period",
              intervalCnt, TB_CLK / benchRate(bellMode, highSpeed));
      lastValid = 1'b1;
      intervalCnt = 0;
      txBit = 1'($urandom % 2);
      pend = 1'b1;
      pendVal = txBit;
    end else if ($urandom % 8 == 0) begin
      txBit = ~txBit; // R5: noise between strobes must be ignored
    end
  endtask

  task automatic runSeg(input logic en, input logic dt, input logic bell,
                        input logic hi, input int n);
    fskEnable = en; dtmfSelect = dt; bellMode = bell; highSpeed = hi;
    lastValid = 1'b0; intervalCnt = 0; segStrobes = 0;
    for (int i = 0; i < n; i++) step();
    if (!(en && !dt)) check(segStrobes == 0, "R3 no strobes idle", segStrobes, 0);
    else check(segStrobes > 0, "R4 strobes present", segStrobes, 1);
  endtask

  task automatic fullIntervals(input logic bell, input logic hi, input int nInt);
    int cnt;
    int lo;
    int rate;
    rate = hi ? 1200 : (bell ? 150 : 75);
    lo = 3579545 / rate;
    fBell = bell; fHi = hi; fEn = 1'b1;
    do @(negedge clk); while (!fStrobe);
    for (int k = 0; k < nInt; k++) begin
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!fStrobe);
      check(cnt == lo || cnt == lo + 1, "R4 fractional period", cnt, lo);
    end
    fEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0d1e));
    repeat (3) @(negedge clk);
    // R1: reset dominates an active configuration
    check(sample == 8'sd0, "R1 reset sample", int'(sample), 0);
    check(sampleValid == 1'b0, "R1 reset valid", int'(sampleValid), 0);
    check(bitStrobe == 1'b0, "R1 reset strobe", int'(bitStrobe), 0);
    rstN = 1'b1;
    runSeg(1, 0, 1, 1, 2000);   // Bell fast
    runSeg(1, 0, 0, 1, 1500);   // V.23 fast
    runSeg(0, 0, 1, 1, 400);    // R3 disabled
    runSeg(1, 0, 1, 1, 800);    // R8 resume from held phase
    runSeg(1, 1, 0, 1, 400);    // R3 dual-tone path selected
    runSeg(1, 0, 1, 0, 2600);   // Bell slow
    runSeg(1, 0, 0, 0, 4000);   // V.23 slow
    for (int s = 0; s < 6; s++)
      runSeg(1'($urandom % 4 != 0), 1'($urandom % 5 == 0), 1'($urandom % 2),
             1'($urandom % 2), 1500 + int'($urandom % 1500));
    runSeg(1, 0, 1, 1, 500);
    // R4: non-integer periods at the real master clock
    fullIntervals(1, 1, 8);
    fullIntervals(1, 0, 3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule